// File: doc/BRIEF.md
# Wiper Shadow Store and Commit Controller

This block keeps the seven stored bytes behind a four-channel digital potentiometer: four power-on wiper positions and three general-purpose bytes. It also keeps the four live 7-bit wiper positions that drive the resistor switches. On reset every live wiper sits at midscale. Once the supply-good input is seen high, each wiper is reloaded from the low seven bits of its stored power-on byte.

A serial decoder in front of this block presents byte writes and reads on a simple register port while chip select is low. A mode input picks the target. When it is set, a write reaches only the live wiper. When it is clear, a write reaches both the live wiper and a slot for the stored copy. The stored copy is committed by a self-timed cycle that starts when chip select rises. During that cycle a busy flag is held and every write is refused. The shutdown output is a combination of the active-low shutdown pin and an enable bit. Shutdown leaves the wiper registers untouched.

Top module: `nvshadow_ctrl`

## Requirements
- R1: From reset until the first cycle in which `supply_good` is sampled high, every wiper lane of `wiper_bus` reads 0x40. Lane i is bits [7i+6:7i].
- R2: At the clock edge where `supply_good` is first sampled high, wiper i takes bits [6:0] of stored byte i. Later changes of `supply_good` have no effect.
- R3: When `wiper_only`=1, a write to an address 0 to 3 updates only that wiper, with bits [6:0] of `wr_data`. The stored bytes are not changed and no commit starts.
- R4: When `wiper_only`=0, a write to an address 0 to 3 updates the wiper at once and arms a commit of that byte. A write to an address 4 to 6 arms a commit of a general-purpose byte and leaves the wipers unchanged.
- R5: An armed commit starts at the first edge where `cs_n` is sampled high after being low. `busy` is then high for exactly COMMIT_CYC cycles. After that, the new byte reads back from the store.
- R6: Only the first stored-byte write of a transaction is armed. Later ones in the same transaction are discarded for the store, but they still update the wiper when they address 0 to 3.
- R7: While `busy` is high, every write is refused, including a write in the cycle in which the commit completes. The wipers, the store and the armed slot stay unchanged.
- R8: `rd_data` shows the following. With `wiper_only`=1 and an address 0 to 3, it shows the live wiper, zero-extended. At any other address 0 to 6, it shows the stored byte. At address 7 it shows 0. Reads never alter a wiper.
- R9: `shutdown` is 1 when `shdn_pin_n` is 0 or `run_en` is 0. Entering and leaving shutdown does not change any wiper.
- R10: A write is ignored in any of these cases: it comes before the recall of R2, it comes while `cs_n` is high, or it targets address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| supply_good | input | 1 | Supply high enough to read the store |
| cs_n | input | 1 | Serial chip select, active low |
| wr_en | input | 1 | Decoded byte write strobe |
| wr_addr | input | 3 | Write address (0-3 wiper channels, 4-6 general purpose) |
| wr_data | input | 8 | Write data |
| wiper_only | input | 1 | 1: live wipers only, 0: stored copy too |
| run_en | input | 1 | Shutdown enable bit, 0 forces shutdown |
| shdn_pin_n | input | 1 | Shutdown pin, active low |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data |
| wiper_bus | output | 28 | Four 7-bit wiper positions |
| busy | output | 1 | Commit in progress |
| shutdown | output | 1 | Combined shutdown, active high |

## Verification
Two events can land on the same edge: the end of a commit and a fresh write strobe. The bench holds the write strobe high with chip select low for longer than the whole commit window. The first write therefore meets the completing edge and must be refused, and the write on the next edge must be taken and armed. A behavioural model in the bench predicts the wipers, `busy` and `rd_data` on every clock, so any shift of one cycle in either rule is reported.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
// Shared types for the wiper shadow store controller.
// Assumes: byte-wide stored registers.
package nvs_pkg;
    localparam int BYTE_W = 8;

    // Recall phase of the live wiper bank.
    typedef enum logic {
        PH_WAIT_SUPPLY = 1'b0,
        PH_RUN         = 1'b1
    } recall_ph_e;

    // Commit engine state.
    typedef enum logic [1:0] {
        CM_IDLE  = 2'd0,
        CM_ARMED = 2'd1,
        CM_BUSY  = 2'd2
    } commit_st_e;
endpackage

// File: rtl/nvs_commit.sv
`timescale 1ns/1ps
// Stored byte array with a single armed slot and a self-timed commit.
// Assumes: nv_req arrives only while chip select is low and the
// engine is not busy (the top gates it); one byte is committed per
// transaction.
module nvs_commit
    import nvs_pkg::*;
#(
    parameter int NV_BYTES   = 7,
    parameter int ADDR_W     = 3,
    parameter int COMMIT_CYC = 16,
    parameter logic [NV_BYTES*BYTE_W-1:0] NV_INIT = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       nv_req,
    input  logic [ADDR_W-1:0]          nv_addr,
    input  logic [BYTE_W-1:0]          nv_data,
    output logic                       busy,
    output logic [NV_BYTES*BYTE_W-1:0] nv_flat
);
    localparam int CNT_W = $clog2(COMMIT_CYC + 1);

    commit_st_e          st_q;
    logic                cs_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [ADDR_W-1:0]   p_addr_q;
    logic [BYTE_W-1:0]   p_data_q;
    logic                cs_rise;
    logic                finish;

    assign cs_rise = !cs_q && cs_n;
    assign finish  = (st_q == CM_BUSY) && (cnt_q == '0);
    assign busy    = (st_q == CM_BUSY);

    // Delayed chip select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    // Arm one byte, start on chip-select rise, count down the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CM_IDLE;
            cnt_q    <= '0;
            p_addr_q <= '0;
            p_data_q <= '0;
        end else begin
            case (st_q)
                CM_IDLE: if (nv_req) begin
                    st_q     <= CM_ARMED;
                    p_addr_q <= nv_addr;
                    p_data_q <= nv_data;
                end
                CM_ARMED: if (cs_rise) begin
                    st_q  <= CM_BUSY;
                    cnt_q <= CNT_W'(COMMIT_CYC - 1);
                end
                CM_BUSY: begin
                    if (cnt_q == '0) st_q <= CM_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= CM_IDLE;
            endcase
        end
    end

    genvar b;
    generate
        for (b = 0; b < NV_BYTES; b++) begin : g_byte
            // Stored byte b: loads its modelled content, updated at commit end.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    nv_flat[b*BYTE_W +: BYTE_W] <= NV_INIT[b*BYTE_W +: BYTE_W];
                else if (finish && p_addr_q == ADDR_W'(b))
                    nv_flat[b*BYTE_W +: BYTE_W] <= p_data_q;
            end
        end
    endgenerate

    // Checker counter: length of the current busy run.
    logic [31:0] busy_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len_q <= '0;
        else if (busy) busy_len_q <= busy_len_q + 1'b1;
        else           busy_len_q <= '0;
    end

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len_q == 32'(COMMIT_CYC)));
    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2)));
    // R7
    busy_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !nv_req);
    // R3
    store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(nv_flat));
endmodule

// File: rtl/nvs_recall.sv
`timescale 1ns/1ps
// Live wiper bank: midscale at reset, one-time recall from the stored
// bytes on supply good, then direct writes per channel.
// Assumes: wr_en is only raised after ready is high.
module nvs_recall
    import nvs_pkg::*;
#(
    parameter int CHANNELS = 4,
    parameter int WIPER_W  = 7,
    parameter int CH_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        supply_good,
    input  logic [CHANNELS*WIPER_W-1:0] init_flat,
    input  logic                        wr_en,
    input  logic [CH_W-1:0]             wr_ch,
    input  logic [WIPER_W-1:0]          wr_val,
    output logic [CHANNELS*WIPER_W-1:0] wiper_flat,
    output logic                        ready
);
    localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);

    recall_ph_e ph_q;
    assign ready = (ph_q == PH_RUN);

    // Leave the waiting phase on the first supply-good sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   ph_q <= PH_WAIT_SUPPLY;
        else if (ph_q == PH_WAIT_SUPPLY && supply_good) ph_q <= PH_RUN;
    end

    genvar c;
    generate
        for (c = 0; c < CHANNELS; c++) begin : g_ch
            // Wiper c: midscale, recall once, then accept writes.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    wiper_flat[c*WIPER_W +: WIPER_W] <= MIDSCALE;
                else if (ph_q == PH_WAIT_SUPPLY) begin
                    if (supply_good)
                        wiper_flat[c*WIPER_W +: WIPER_W] <= init_flat[c*WIPER_W +: WIPER_W];
                end else if (wr_en && wr_ch == CH_W'(c))
                    wiper_flat[c*WIPER_W +: WIPER_W] <= wr_val;
            end

            // R1
            midscale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !ready |-> (wiper_flat[c*WIPER_W +: WIPER_W] == MIDSCALE));
        end
    endgenerate

    // R2
    recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (wiper_flat == $past(init_flat)));
endmodule

// File: rtl/nvshadow_ctrl.sv
`timescale 1ns/1ps
// Top: gates decoded writes, splits them between the live wiper bank
// and the commit engine, serves reads and forms the shutdown output.
// Assumes: addresses 0..CHANNELS-1 are wiper channels and the next
// GP_BYTES addresses are general-purpose stored bytes.
module nvshadow_ctrl
    import nvs_pkg::*;
#(
    parameter int CHANNELS   = 4,
    parameter int GP_BYTES   = 3,
    parameter int WIPER_W    = 7,
    parameter int COMMIT_CYC = 4_000_000,
    parameter logic [(CHANNELS+GP_BYTES)*8-1:0] NV_INIT = 56'hC3B2A1_55007F10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                supply_good,
    input  logic                                cs_n,
    input  logic                                wr_en,
    input  logic [$clog2(CHANNELS+GP_BYTES+1)-1:0] wr_addr,
    input  logic [7:0]                          wr_data,
    input  logic                                wiper_only,
    input  logic                                run_en,
    input  logic                                shdn_pin_n,
    input  logic [$clog2(CHANNELS+GP_BYTES+1)-1:0] rd_addr,
    output logic [7:0]                          rd_data,
    output logic [CHANNELS*WIPER_W-1:0]         wiper_bus,
    output logic                                busy,
    output logic                                shutdown
);
    localparam int NV_BYTES = CHANNELS + GP_BYTES;
    localparam int ADDR_W   = $clog2(NV_BYTES + 1);
    localparam int CH_W     = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

    logic                        ready;
    logic                        accept;
    logic                        wiper_wr;
    logic                        nv_req;
    logic [NV_BYTES*BYTE_W-1:0]  nv_flat;
    logic [CHANNELS*WIPER_W-1:0] init_flat;

    assign accept   = wr_en && !cs_n && !busy && ready && (wr_addr < ADDR_W'(NV_BYTES));
    assign wiper_wr = accept && (wr_addr < ADDR_W'(CHANNELS));
    assign nv_req   = accept && !wiper_only;
    assign shutdown = !shdn_pin_n || !run_en;

    genvar c;
    generate
        for (c = 0; c < CHANNELS; c++) begin : g_init
            assign init_flat[c*WIPER_W +: WIPER_W] = nv_flat[c*BYTE_W +: WIPER_W];
        end
    endgenerate

    nvs_recall #(
        .CHANNELS (CHANNELS),
        .WIPER_W  (WIPER_W),
        .CH_W     (CH_W)
    ) u_recall (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_good (supply_good),
        .init_flat   (init_flat),
        .wr_en       (wiper_wr),
        .wr_ch       (wr_addr[CH_W-1:0]),
        .wr_val      (wr_data[WIPER_W-1:0]),
        .wiper_flat  (wiper_bus),
        .ready       (ready)
    );

    nvs_commit #(
        .NV_BYTES   (NV_BYTES),
        .ADDR_W     (ADDR_W),
        .COMMIT_CYC (COMMIT_CYC),
        .NV_INIT    (NV_INIT)
    ) u_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .nv_req  (nv_req),
        .nv_addr (wr_addr),
        .nv_data (wr_data),
        .busy    (busy),
        .nv_flat (nv_flat)
    );

    // Read mux: live wiper in wiper-only mode, stored byte otherwise.
    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NV_BYTES)) begin
            if (wiper_only && rd_addr < ADDR_W'(CHANNELS))
                rd_data = BYTE_W'(wiper_bus[int'(rd_addr)*WIPER_W +: WIPER_W]);
            else
                rd_data = nv_flat[int'(rd_addr)*BYTE_W +: BYTE_W];
        end
    end

    // R7
    wiper_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wiper_bus));
endmodule

// File: tb/nvshadow_ctrl_bench.sv
`timescale 1ns/1ps
module nvshadow_ctrl_bench;
    localparam int CC = 16;
    localparam logic [55:0] INIT = 56'hC3B2A1_55007F10;

    logic clk = 0, rst_n = 0, supply_good = 0, cs_n = 1, wr_en = 0;
    logic [2:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic wiper_only = 0, run_en = 1, shdn_pin_n = 1;
    logic [27:0] wiper_bus;
    logic busy, shutdown;

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nvshadow_ctrl #(.COMMIT_CYC(CC), .NV_INIT(INIT)) u_nvshadow_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .cs_n(cs_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wiper_only(wiper_only), .run_en(run_en), .shdn_pin_n(shdn_pin_n),
        .rd_addr(rd_addr), .rd_data(rd_data), .wiper_bus(wiper_bus),
        .busy(busy), .shutdown(shutdown));

    // Behavioural reference model.
    int m_w[4], m_nv[7];
    bit m_ready, m_busy, m_pend, m_csq, m_rise, m_acc;
    int m_left, m_paddr, m_pdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_w[i] = 64;
            for (int i = 0; i < 7; i++) m_nv[i] = int'(INIT[i*8 +: 8]);
            m_ready = 0; m_busy = 0; m_pend = 0; m_csq = 1; m_left = 0;
        end else begin
            m_rise = !m_csq && cs_n;
            m_acc  = wr_en && !cs_n && !m_busy && m_ready && wr_addr < 7;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin m_busy = 0; m_nv[m_paddr] = m_pdata; end
            end else if (m_pend && m_rise) begin
                m_pend = 0; m_busy = 1; m_left = CC;
            end
            if (!m_ready) begin
                if (supply_good) begin
                    for (int i = 0; i < 4; i++) m_w[i] = m_nv[i] & 127;
                    m_ready = 1;
                end
            end else if (m_acc) begin
                if (wr_addr < 4) m_w[wr_addr] = wr_data & 127;
                if (!wiper_only && !m_pend) begin
                    m_pend = 1; m_paddr = wr_addr; m_pdata = wr_data;
                end
            end
            m_csq = cs_n;
        end
    end

    function automatic int exp_rd();
        if (rd_addr >= 7) return 0;
        if (wiper_only && rd_addr < 4) return m_w[rd_addr];
        return m_nv[rd_addr];
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, got, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !finished) begin
            for (int i = 0; i < 4; i++) chk("R1 R2 R3 R4 R6 wiper lane", int'(wiper_bus[i*7 +: 7]), m_w[i]);
            chk("R5 R7 busy", int'(busy), int'(m_busy));
            chk("R9 shutdown", int'(shutdown), int'(!shdn_pin_n || !run_en));
            chk("R8 read data", int'(rd_data), exp_rd());
        end
    end

    task automatic step(); @(negedge clk); #1; endtask
    task automatic wr(int a, int d);
        step(); wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
        step(); wr_en = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: midscale during reset
        for (int i = 0; i < 4; i++) chk("R1 midscale in reset", int'(wiper_bus[i*7 +: 7]), 'h40);
        chk("R1 busy in reset", int'(busy), 0);
        #1 rst_n = 1;
        // R10: write before recall ignored
        step(); cs_n = 0; wr(0, 'h22); step(); cs_n = 1;
        @(negedge clk); chk("R10 write before recall", int'(wiper_bus[6:0]), 'h40);
        // R2: recall
        #1 supply_good = 1;
        @(negedge clk);
        chk("R2 recall ch0", int'(wiper_bus[6:0]), 'h10);
        chk("R2 recall ch1 top code", int'(wiper_bus[13:7]), 'h7F);
        chk("R2 recall ch2 bottom code", int'(wiper_bus[20:14]), 'h00);
        chk("R2 recall ch3", int'(wiper_bus[27:21]), 'h55);
        #1 supply_good = 0; step(); supply_good = 1;
        @(negedge clk); chk("R2 no second recall", int'(wiper_bus[6:0]), 'h10);
        // R3: wiper-only write
        #1 wiper_only = 1; cs_n = 0; wr(1, 'h85); step(); cs_n = 1; step();
        @(negedge clk);
        chk("R3 wiper-only write", int'(wiper_bus[13:7]), 'h05);
        chk("R3 no commit", int'(busy), 0);
        #1 rd_addr = 1;
        @(negedge clk); chk("R8 live read", int'(rd_data), 'h05);
        #1 wiper_only = 0;
        @(negedge clk); chk("R3 R8 store untouched", int'(rd_data), 'h7F);
        // R4 R6: two stored writes in one transaction
        #1 cs_n = 0; wr(2, 'h33); wr(3, 'h44);
        @(negedge clk);
        chk("R4 wiper2 at once", int'(wiper_bus[20:14]), 'h33);
        chk("R6 wiper3 still updated", int'(wiper_bus[27:21]), 'h44);
        #1 cs_n = 1;
        @(negedge clk); chk("R5 busy after cs rise", int'(busy), 1);
        // R7: write held across the completing edge
        #1 cs_n = 0; wr_en = 1; wr_addr = 0; wr_data = 'h11;
        repeat (CC + 2) step();
        wr_en = 0;
        @(negedge clk);
        chk("R7 write after completion taken", int'(wiper_bus[6:0]), 'h11);
        #1 cs_n = 1; n = 0;
        @(negedge clk);
        while (busy) begin n++; @(negedge clk); end
        chk("R5 busy length", n, CC);
        #1 rd_addr = 2; @(negedge clk); chk("R5 committed ch2", int'(rd_data), 'h33);
        #1 rd_addr = 3; @(negedge clk); chk("R6 second byte dropped", int'(rd_data), 'h55);
        #1 rd_addr = 0; @(negedge clk); chk("R5 committed ch0", int'(rd_data), 'h11);
        // R4: general-purpose byte
        #1 cs_n = 0; wr(5, 'hA5); step(); cs_n = 1;
        repeat (CC + 3) step();
        rd_addr = 5; @(negedge clk); chk("R4 gp byte stored", int'(rd_data), 'hA5);
        // R10: address 7 and chip select high
        #1 cs_n = 0; wr(7, 'h99); step(); cs_n = 1;
        @(negedge clk); @(negedge clk); chk("R10 addr 7 no commit", int'(busy), 0);
        #1 rd_addr = 7; @(negedge clk); chk("R8 addr 7 reads zero", int'(rd_data), 0);
        #1 wr(0, 'h01); @(negedge clk); chk("R10 cs high ignored", int'(wiper_bus[6:0]), 'h11);
        // R9: shutdown combinations
        #1 shdn_pin_n = 0; @(negedge clk); chk("R9 pin low", int'(shutdown), 1);
        #1 run_en = 0; @(negedge clk); chk("R9 both", int'(shutdown), 1);
        #1 shdn_pin_n = 1; @(negedge clk); chk("R9 bit low", int'(shutdown), 1);
        #1 run_en = 1; @(negedge clk); chk("R9 normal", int'(shutdown), 0);
        chk("R9 wiper kept", int'(wiper_bus[6:0]), 'h11);
        repeat (4) @(negedge clk);
        finished = 1;
        summary();
    end
endmodule